// File: doc/BRIEF.md
# Three-Channel Compare Watchdog

This block holds three watchdog channels behind one 32-bit register port. Each channel has a free-running up-counter that advances on a shared reference tick. Software can write any value into the counter at any time. The counter is compared, unsigned and with greater-or-equal, against a bite threshold. When the channel's reset enable is set and the comparison holds, the channel requests a reset. Channel 0 requests a recovery-mode reset. Channels 1 and 2 request an ordinary system reset.

Channel 0 also has a bark threshold and an interrupt. Its status bit sets when the interrupt is enabled and the counter has reached the bark threshold. Writing a one to the status bit clears it. Software keeps a channel alive by writing zero to its counter.

Software can force an immediate restart. It sets reset enable, then writes zero to the bite threshold while the counter is zero. Since zero is greater than or equal to zero, the reset request rises at once.

Top module: `cmp_wdog`

## Requirements
- R1: After reset, every counter reads 0, every bite and bark threshold reads 0xFFFFFFFF, every control register reads 0, and the outputs `rst_recovery_req`, `rst_system_req` and `irq` are low.
- R2: Registers sit at these word offsets. Channel n (n = 0, 1, 2) has its counter at 0x10*n, its bite threshold at 0x10*n+0x4 and its control at 0x10*n+0xC. Only channel 0 has a bark threshold, at 0x08.
- R3: Control bit 0 is interrupt enable, bit 1 is interrupt status and bit 2 is reset enable. Every other bit reads 0. On channels 1 and 2, bits 0 and 1 always read 0.
- R4: On each cycle with `tick` high, a counter rises by exactly 1. It wraps from 0xFFFFFFFF to 0.
- R5: A bus write to a counter loads the written value. The write wins over a tick in the same cycle.
- R6: The reset request is a level. It is high while reset enable is set and the counter is, unsigned, at or above the bite threshold. Channel 0 drives `rst_recovery_req`; channels 1 and 2 drive `rst_system_req`. The request is visible in the cycle after the register write or tick that creates the condition.
- R7: With reset enable set and the counter at 0, writing 0 to the bite threshold raises the reset request directly after that write.
- R8: Channel 0 status sets on the clock edge after interrupt enable is set and the counter is at or above the bark threshold. `irq` equals status AND interrupt enable.
- R9: Writing control with bit 1 = 1 clears status, unless the bark condition holds in that cycle, in which case status stays set. Writing bit 1 = 0 leaves status unchanged.
- R10: Reads of unmapped offsets return 0. These are: 0x18, 0x28, anything at 0x30 and above, and any offset with bits 1:0 not zero. Writes to unmapped offsets change no register.
- R11: Channels are independent. Writing one channel does not change another channel's registers or reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference-clock tick enable for all counters |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rst_recovery_req | output | 1 | Recovery-mode reset request from channel 0 |
| rst_system_req | output | 1 | System reset request from channel 1 or 2 |
| irq | output | 1 | Channel 0 bark interrupt |

## Verification
The bench targets four corner cases:

- **Comparison.** The 0 >= 0 restart case and a counter of 0x80000000 against a small bite value. A signed comparison, or a strict greater-than, would leave the reset request low.
- **Counter edges.** Counter wrap past 0xFFFFFFFF, and a write that coincides with a tick. A saturating counter, or one that lets the tick win, would read back the wrong value.
- **Status.** A clear while the bark condition still holds must keep status set. A write of zero to the status bit must not clear it. Wrong priority shows up as a status bit that drops or that cannot be cleared.
- **Decoding.** Unmapped holes and offsets above the map must not alias onto real registers. A decoder that ignores the upper address bits would overwrite channel 0's bite threshold.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW      = 32;
  localparam int ADDR_W  = 8;
  localparam int NCH     = 3;
  // control bit positions
  localparam int CB_IEN  = 0;
  localparam int CB_STS  = 1;
  localparam int CB_REN  = 2;
  // register index inside a channel (addr[3:2])
  localparam logic [1:0] RI_CNT  = 2'd0;
  localparam logic [1:0] RI_BITE = 2'd1;
  localparam logic [1:0] RI_BARK = 2'd2;
  localparam logic [1:0] RI_CTRL = 2'd3;

  // threshold reached: unsigned greater-or-equal
  function automatic logic reached(input logic [DW-1:0] cnt, input logic [DW-1:0] thr);
    return cnt >= thr;
  endfunction

  // next counter value: write beats tick, wrap on overflow
  function automatic logic [DW-1:0] next_cnt(input logic [DW-1:0] cur, input logic wr,
                                             input logic [DW-1:0] wd, input logic tk);
    if (wr)      return wd;
    else if (tk) return cur + 1'b1;
    else         return cur;
  endfunction
endpackage

// File: rtl/wdt_addr_dec.sv
module wdt_addr_dec
  import wdt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NC = NCH
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  output logic            hit,
  output logic [1:0]      ch_idx,
  output logic [1:0]      reg_idx,
  output logic [NC-1:0][3:0] wr_sel
);
  logic hi_zero, aligned, ch_ok, reg_ok;

  assign ch_idx  = addr[5:4];
  assign reg_idx = addr[3:2];
  assign hi_zero = (addr[AW-1:6] == '0);
  assign aligned = (addr[1:0] == 2'b00);
  assign ch_ok   = (int'(ch_idx) < NC);
  assign reg_ok  = (reg_idx != RI_BARK) || (ch_idx == 2'd0);
  assign hit     = hi_zero && aligned && ch_ok && reg_ok;

  always_comb begin
    wr_sel = '0;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 4; r++)
        wr_sel[c][r] = wr && hit && (int'(ch_idx) == c) && (int'(reg_idx) == r);
  end
endmodule

// File: rtl/wdt_chan.sv
module wdt_chan
  import wdt_pkg::*;
#(
  parameter bit HAS_BARK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] wdata,
  input  logic          wr_cnt,
  input  logic          wr_bite,
  input  logic          wr_bark,
  input  logic          wr_ctrl,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] bite_o,
  output logic [DW-1:0] bark_o,
  output logic [DW-1:0] ctrl_o,
  output logic          irq_en_o,
  output logic          sts_o,
  output logic          rst_en_o,
  output logic          bark_hit_o,
  output logic          rst_req_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, bite_q;
  logic          ren_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bite_q <= '1;
      ren_q  <= 1'b0;
    end else begin
      cnt_q <= next_cnt(cnt_q, wr_cnt, wdata, tick);
      if (wr_bite) bite_q <= wdata;
      if (wr_ctrl) ren_q  <= wdata[CB_REN];
    end
  end

  generate
    if (HAS_BARK) begin : g_bark
      logic [DW-1:0] bark_q;
      logic          ien_q, sts_q, set_w, clr_w;
      assign set_w = ien_q && reached(cnt_q, bark_q);
      assign clr_w = wr_ctrl && wdata[CB_STS];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bark_q <= '1;
          ien_q  <= 1'b0;
          sts_q  <= 1'b0;
        end else begin
          if (wr_bark) bark_q <= wdata;
          if (wr_ctrl) ien_q  <= wdata[CB_IEN];
          sts_q <= (sts_q && !clr_w) || set_w;
        end
      end
      assign bark_o     = bark_q;
      assign irq_en_o   = ien_q;
      assign sts_o      = sts_q;
      assign bark_hit_o = set_w;
    end else begin : g_nobark
      logic unused_bark;
      assign unused_bark = wr_bark;
      assign bark_o     = '0;
      assign irq_en_o   = 1'b0;
      assign sts_o      = 1'b0;
      assign bark_hit_o = 1'b0;
    end
  endgenerate

  assign cnt_o     = cnt_q;
  assign bite_o    = bite_q;
  assign rst_en_o  = ren_q;
  assign ctrl_o    = {{(DW-3){1'b0}}, ren_q, sts_o, irq_en_o};
  assign rst_req_o = ren_q && reached(cnt_q, bite_q);
  assign irq_o     = sts_o && irq_en_o;
endmodule

// File: rtl/cmp_wdog.sv
module cmp_wdog
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              rst_recovery_req,
  output logic              rst_system_req,
  output logic              irq
);
  logic                        hit_w;
  logic [1:0]                  ch_w, rg_w;
  logic [NCH-1:0][3:0]         wr_sel;
  logic [NCH-1:0][DW-1:0]      cnt_w, bite_w, bark_w, ctrl_w;
  logic [NCH-1:0]              ien_w, sts_w, ren_w, bhit_w, rreq_w, irq_w;

  wdt_addr_dec #(.AW(ADDR_W), .NC(NCH)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .hit(hit_w),
    .ch_idx(ch_w), .reg_idx(rg_w), .wr_sel(wr_sel)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      wdt_chan #(.HAS_BARK(c == 0)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wdata(bus_wdata),
        .wr_cnt(wr_sel[c][RI_CNT]), .wr_bite(wr_sel[c][RI_BITE]),
        .wr_bark(wr_sel[c][RI_BARK]), .wr_ctrl(wr_sel[c][RI_CTRL]),
        .cnt_o(cnt_w[c]), .bite_o(bite_w[c]), .bark_o(bark_w[c]), .ctrl_o(ctrl_w[c]),
        .irq_en_o(ien_w[c]), .sts_o(sts_w[c]), .rst_en_o(ren_w[c]),
        .bark_hit_o(bhit_w[c]), .rst_req_o(rreq_w[c]), .irq_o(irq_w[c])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (hit_w) begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(ch_w) == c) begin
          case (rg_w)
            RI_CNT:  bus_rdata = cnt_w[c];
            RI_BITE: bus_rdata = bite_w[c];
            RI_BARK: bus_rdata = bark_w[c];
            default: bus_rdata = ctrl_w[c];
          endcase
        end
      end
    end
  end

  assign rst_recovery_req = rreq_w[0];
  assign rst_system_req   = |rreq_w[NCH-1:1];
  assign irq              = irq_w[0];
endmodule

// File: rtl/cmp_wdog_chk.sv
module cmp_wdog_chk
  import wdt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [DW-1:0] wdata,
  input logic          wr_cnt0,
  input logic          wr_ctrl0,
  input logic [DW-1:0] cnt0,
  input logic          ien0,
  input logic          ren0,
  input logic          sts0,
  input logic          bark_hit0,
  input logic          irq,
  input logic          rst_recovery_req
);
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt0) |=> cnt0 == DW'($past(cnt0) + 1'b1));
  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt0 |=> cnt0 == $past(wdata));
  // R6
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ren0 |-> !rst_recovery_req);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien0 && sts0));
  // R8
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bark_hit0 |=> sts0);
  // R9
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl0 && wdata[CB_STS] && !bark_hit0) |=> !sts0);
  // R9
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts0 && !(wr_ctrl0 && wdata[CB_STS])) |=> sts0);
endmodule

bind cmp_wdog cmp_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wdata(bus_wdata),
  .wr_cnt0(wr_sel[0][0]), .wr_ctrl0(wr_sel[0][3]), .cnt0(cnt_w[0]),
  .ien0(ien_w[0]), .ren0(ren_w[0]), .sts0(sts_w[0]), .bark_hit0(bhit_w[0]),
  .irq(irq), .rst_recovery_req(rst_recovery_req)
);

// File: tb/cmp_wdog_tb.sv
module cmp_wdog_tb;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rst_recovery_req, rst_system_req, irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_wdog u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    rchk("R1 cnt0", 8'h00, 32'h0);
    rchk("R1 bite0", 8'h04, 32'hFFFF_FFFF);
    rchk("R1 bark0", 8'h08, 32'hFFFF_FFFF);
    rchk("R1 ctrl0", 8'h0C, 32'h0);
    rchk("R1 bite1", 8'h14, 32'hFFFF_FFFF);
    rchk("R1 ctrl2", 8'h2C, 32'h0);
    check("R1 outputs", {rst_recovery_req, rst_system_req, irq}, 32'h0);
  endtask

  task automatic t_count;
    ticks(5);
    rchk("R4 count five", 8'h00, 32'd5);
    rchk("R2 cnt2 at 0x20", 8'h20, 32'd5);
    wr(8'h10, 32'hFFFF_FFFE);
    ticks(3);
    rchk("R4 wrap", 8'h10, 32'd1);
  endtask

  task automatic t_wr_prio;
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'd100;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    rchk("R5 write beats tick", 8'h20, 32'd100);
  endtask

  task automatic t_bite;
    wr(8'h10, 32'd0); wr(8'h14, 32'd10); wr(8'h1C, 32'h4);
    check("R6 below bite", rst_system_req, 1'b0);
    ticks(9);
    check("R6 at 9", rst_system_req, 1'b0);
    ticks(1);
    check("R6 at bite", rst_system_req, 1'b1);
    check("R11 ch0 untouched", rst_recovery_req, 1'b0);
    ticks(2);
    check("R6 level held", rst_system_req, 1'b1);
    wr(8'h1C, 32'h0);
    check("R6 enable off", rst_system_req, 1'b0);
    wr(8'h24, 32'd5); wr(8'h20, 32'h8000_0000); wr(8'h2C, 32'h4);
    check("R6 unsigned ch2", rst_system_req, 1'b1);
    check("R11 ch2 no recovery", rst_recovery_req, 1'b0);
    rchk("R11 ch1 bite kept", 8'h14, 32'd10);
    wr(8'h2C, 32'h0);
    check("R6 ch2 off", rst_system_req, 1'b0);
  endtask

  task automatic t_restart;
    wr(8'h00, 32'd0); wr(8'h0C, 32'h4);
    check("R7 armed no reset", rst_recovery_req, 1'b0);
    wr(8'h04, 32'd0);
    check("R7 immediate", rst_recovery_req, 1'b1);
    check("R7 system low", rst_system_req, 1'b0);
    wr(8'h0C, 32'h0); wr(8'h04, 32'hFFFF_FFFF);
    check("R7 released", rst_recovery_req, 1'b0);
  endtask

  task automatic t_bark;
    wr(8'h08, 32'd3); wr(8'h00, 32'd0); wr(8'h0C, 32'h1);
    ticks(3);
    check("R8 not yet", irq, 1'b0);
    @(negedge clk);
    check("R8 irq set", irq, 1'b1);
    rchk("R3 ctrl0 bits", 8'h0C, 32'h3);
    wr(8'h0C, 32'h3);
    rchk("R9 clear while held", 8'h0C, 32'h3);
    wr(8'h00, 32'd0);
    wr(8'h0C, 32'h1);
    rchk("R9 write zero keeps", 8'h0C, 32'h3);
    wr(8'h0C, 32'h0);
    check("R8 masked irq", irq, 1'b0);
    rchk("R8 status kept masked", 8'h0C, 32'h2);
    wr(8'h0C, 32'h3);
    rchk("R9 cleared", 8'h0C, 32'h1);
    check("R9 irq low", irq, 1'b0);
    wr(8'h0C, 32'h0); wr(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_map;
    wr(8'h1C, 32'h7);
    rchk("R3 ch1 ctrl", 8'h1C, 32'h4);
    wr(8'h1C, 32'h0);
    wr(8'h34, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h06, 32'h0);
    wr(8'h44, 32'h0);
    rchk("R10 bite0 kept", 8'h04, 32'hFFFF_FFFF);
    rchk("R10 bark0 kept", 8'h08, 32'hFFFF_FFFF);
    rchk("R10 bite1 kept", 8'h14, 32'd10);
    rchk("R10 read 0x18", 8'h18, 32'h0);
    rchk("R10 read 0x28", 8'h28, 32'h0);
    rchk("R10 read 0x34", 8'h34, 32'h0);
    rchk("R10 read 0x05", 8'h05, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wr_prio();
    t_bite();
    t_restart();
    t_bark();
    t_map();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule